// File: doc/BRIEF.md
# Multiprocessor Nine-Bit Serial Port

This block is an asynchronous serial port run from a single 8-bit control register and a data register. A two-bit mode field selects an 8-bit frame or one of two 9-bit frames; in the 9-bit frames the processor supplies the extra transmitted bit through a control bit, and the extra received bit is captured into a read-only status bit. The receive path oversamples the line sixteen times per bit and votes on three samples around mid-bit.

A multiprocessor filter lets one port sit on a shared line with many peers: with the filter on, only frames whose extra bit is 1 (address frames) complete a reception, so a node sleeps through data meant for others until software turns the filter off. The baud-rate tick comes from outside at sixteen times the bit rate. Transmit and receive completion raise sticky flags whose OR drives the interrupt output.

Top module: `mp_uart`

## Requirements
- R1: After reset the control register reads 0x00, the data register reads 0x00, `txd` is high and `irq` is low.
- R2: Address 0 is the control register, address 1 the data register. Control bits: [0] receive enable, [1] multiprocessor filter, [2] transmit extra bit, [3] received extra bit (read-only, writes leave it unchanged), [4] transmit-done flag, [5] receive-done flag, [7:6] mode (00 unsupported, 01 8-bit frame, 10 and 11 both 9-bit frames).
- R3: Writing the data register in modes 01, 10 or 11 while the transmitter is idle sends a low start bit, 8 data bits LSB first, the transmit extra bit in the 9-bit modes only, then a high stop bit, each bit lasting 16 baud ticks; a data write while a frame is being sent is ignored.
- R4: The transmit-done flag sets at the end of the stop bit and stays set until software writes 0 to it.
- R5: Each received bit is the majority of ticks 7, 8 and 9 of its 16; a start bit that is not low by that vote is abandoned without any reception.
- R6: With receive enable clear, or in mode 00, nothing is received; mode 00 also sends nothing on a data write.
- R7: In mode 01 with the filter clear, every frame completes: the data register takes the byte, the received extra bit takes the stop bit value (0 or 1), the receive-done flag sets.
- R8: In mode 01 with the filter set, a frame whose stop bit is 0 is discarded: flag, data register and received extra bit all unchanged.
- R9: In the 9-bit modes with the filter clear, every frame completes and the received extra bit takes the ninth received bit.
- R10: In the 9-bit modes with the filter set, a frame whose ninth bit is 0 is discarded (flag, data register and received extra bit unchanged); one whose ninth bit is 1 completes.
- R11: `irq` is high exactly when the transmit-done or receive-done flag is set.
- R12: When hardware sets a done flag in the same cycle as a software write to the control register, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 1 | Register select: 0 control, 1 data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idles high |
| txd | output | 1 | Serial transmit line, idles high |
| irq | output | 1 | Interrupt, OR of the two done flags |

## Verification
The receiver setting its done flag and software writing the control register to clear that same flag can land on one clock edge. The bench provokes this by rewriting the control register with the flag at 0 on every cycle through the received stop bit and stopping the writes as soon as `irq` rises, so the final write coincides with the hardware set. It then judges that a write was in flight on that edge and that the flag, `irq` and the data register all show the completed frame.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    localparam int DW = 8;
    localparam int FRAME_MAX = DW + 3;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_8B   = 2'b01,
        MODE_9A   = 2'b10,
        MODE_9B   = 2'b11
    } mode_e;

    // Control register image, MSB first.
    typedef struct packed {
        mode_e mode;   // [7:6]
        logic  ri;     // [5] receive done
        logic  ti;     // [4] transmit done
        logic  rx9;    // [3] received extra bit, read-only
        logic  tx9;    // [2] transmit extra bit
        logic  mp_en;  // [1] address filter
        logic  rx_en;  // [0] receive enable
    } ctrl_t;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          bit9;
    } rx_frame_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic is_nine(input mode_e m);
        return m[1];
    endfunction

    function automatic logic is_active(input mode_e m);
        return m != MODE_NONE;
    endfunction

endpackage

// File: rtl/mpu_regs.sv
module mpu_regs
    import mpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          addr,
    input  logic [7:0]    wdata,
    input  logic          rx_done,
    input  rx_frame_t     rx_frame,
    input  logic          tx_done,
    output ctrl_t         ctrl,
    output logic [7:0]    rdata,
    output logic          tx_start
);

    ctrl_t         ctrl_n;
    logic [DW-1:0] rbuf;
    logic          wr_ctrl;
    logic          rx_accept;

    assign wr_ctrl   = wr && (addr == ADDR_CTRL);
    assign tx_start  = wr && (addr == ADDR_DATA);
    // Filter: with mp_en set only frames whose extra bit is 1 complete.
    assign rx_accept = rx_done && (!ctrl.mp_en || rx_frame.bit9);

    always_comb begin
        ctrl_n = ctrl;
        if (wr_ctrl) begin
            ctrl_n     = ctrl_t'(wdata);
            ctrl_n.rx9 = ctrl.rx9;
        end
        // Hardware sets are applied after the software write: they win.
        if (tx_done) ctrl_n.ti = 1'b1;
        if (rx_accept) begin
            ctrl_n.ri  = 1'b1;
            ctrl_n.rx9 = rx_frame.bit9;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            rbuf <= '0;
        end else begin
            ctrl <= ctrl_n;
            if (rx_accept) rbuf <= rx_frame.data;
        end
    end

    assign rdata = (addr == ADDR_CTRL) ? 8'(ctrl) : rbuf;

    p_ri_set_r12: assert property (@(posedge clk) disable iff (rst)
        rx_accept |=> ctrl.ri);

    p_ti_set_r12: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> ctrl.ti);

    p_rx9_ro_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl.rx9) |-> $past(rx_accept));

    p_ti_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.ti && !wr_ctrl) |=> ctrl.ti);

    p_mp_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_done && ctrl.mp_en && !rx_frame.bit9) |=> $stable(rbuf));

endmodule

// File: rtl/mpu_tx.sv
module mpu_tx
    import mpu_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  mode_e         mode,
    input  logic          start,
    input  logic [DW-1:0] data,
    input  logic          bit9,
    output logic          txd,
    output logic          done
);

    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(FRAME_MAX + 1);
    localparam logic [CW-1:0] T_END = CW'(OSR - 1);

    typedef enum logic {TX_IDLE, TX_RUN} tx_st_e;

    tx_st_e                 st;
    logic [FRAME_MAX-1:0]   shreg;
    logic [CW-1:0]          tcnt;
    logic [BW-1:0]          bit_idx;
    logic [BW-1:0]          nbits;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= TX_IDLE;
            shreg   <= '1;
            tcnt    <= '0;
            bit_idx <= '0;
            nbits   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                TX_IDLE: begin
                    if (start && is_active(mode)) begin
                        // stop, extra (or second stop-level filler), data, start
                        shreg   <= {1'b1, (is_nine(mode) ? bit9 : 1'b1), data, 1'b0};
                        nbits   <= is_nine(mode) ? BW'(FRAME_MAX) : BW'(FRAME_MAX - 1);
                        bit_idx <= '0;
                        tcnt    <= '0;
                        st      <= TX_RUN;
                    end
                end
                default: begin
                    if (tick) begin
                        if (tcnt == T_END) begin
                            tcnt  <= '0;
                            shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
                            if (bit_idx == nbits - 1'b1) begin
                                st   <= TX_IDLE;
                                done <= 1'b1;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign txd = (st == TX_RUN) ? shreg[0] : 1'b1;

    p_no_tx_mode0_r6: assert property (@(posedge clk) disable iff (rst)
        (st == TX_IDLE && start && !is_active(mode)) |=> (st == TX_IDLE));

    p_tx_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (st == TX_RUN && !tick) |=> $stable(shreg));

endmodule

// File: rtl/mpu_rx.sv
module mpu_rx
    import mpu_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2   // at least 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  logic      enable,
    input  logic      nine,
    output logic      done,
    output rx_frame_t frame
);

    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR / 2;
    localparam int IW  = $clog2(DW + 2);
    localparam logic [CW-1:0] S_LO  = CW'(MID - 1);
    localparam logic [CW-1:0] S_MID = CW'(MID);
    localparam logic [CW-1:0] S_HI  = CW'(MID + 1);
    localparam logic [CW-1:0] S_END = CW'(OSR - 1);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_st_e;

    rx_st_e                 st;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line;
    logic [CW-1:0]          tcnt;
    logic                   samp_a;
    logic                   samp_b;
    logic                   bitval;
    logic [DW:0]            shreg;
    logic [IW-1:0]          idx;
    logic [IW-1:0]          nbits;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end

    assign line   = sync_q[SYNC_STAGES-1];
    assign bitval = maj3(samp_a, samp_b, line);
    assign nbits  = nine ? IW'(DW + 1) : IW'(DW);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RX_IDLE;
            tcnt   <= '0;
            samp_a <= 1'b1;
            samp_b <= 1'b1;
            shreg  <= '0;
            idx    <= '0;
            done   <= 1'b0;
            frame  <= '0;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                st <= RX_IDLE;
            end else if (tick) begin
                if (st == RX_IDLE) begin
                    if (!line) begin
                        st   <= RX_START;
                        tcnt <= CW'(1);
                        idx  <= '0;
                    end
                end else begin
                    tcnt <= (tcnt == S_END) ? '0 : tcnt + 1'b1;
                    if (tcnt == S_LO)  samp_a <= line;
                    if (tcnt == S_MID) samp_b <= line;
                    if (tcnt == S_HI) begin
                        case (st)
                            RX_START: if (bitval) st <= RX_IDLE;
                            RX_BITS: begin
                                shreg <= {bitval, shreg[DW:1]};
                                idx   <= idx + 1'b1;
                            end
                            RX_STOP: begin
                                st         <= RX_IDLE;
                                done       <= 1'b1;
                                frame.data <= nine ? shreg[DW-1:0] : shreg[DW:1];
                                frame.bit9 <= nine ? shreg[DW] : bitval;
                            end
                            default: ;
                        endcase
                    end
                    if (tcnt == S_END) begin
                        if (st == RX_START)                    st <= RX_BITS;
                        else if (st == RX_BITS && idx == nbits) st <= RX_STOP;
                    end
                end
            end
        end
    end

    p_rx_off_r6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (st == RX_IDLE && !done));

    p_rx_done_stop_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(st) == RX_STOP));

endmodule

// File: rtl/mp_uart.sv
module mp_uart
    import mpu_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       baud_tick,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);

    ctrl_t     ctrl;
    rx_frame_t rx_frame;
    logic      rx_done;
    logic      tx_done;
    logic      tx_start;
    logic      rx_enable;

    assign rx_enable = ctrl.rx_en && is_active(ctrl.mode);

    mpu_regs regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rx_done  (rx_done),
        .rx_frame (rx_frame),
        .tx_done  (tx_done),
        .ctrl     (ctrl),
        .rdata    (reg_rdata),
        .tx_start (tx_start)
    );

    mpu_tx #(.OSR(OSR)) tx_i (
        .clk   (clk),
        .rst   (rst),
        .tick  (baud_tick),
        .mode  (ctrl.mode),
        .start (tx_start),
        .data  (reg_wdata),
        .bit9  (ctrl.tx9),
        .txd   (txd),
        .done  (tx_done)
    );

    mpu_rx #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) rx_i (
        .clk    (clk),
        .rst    (rst),
        .tick   (baud_tick),
        .rxd    (rxd),
        .enable (rx_enable),
        .nine   (is_nine(ctrl.mode)),
        .done   (rx_done),
        .frame  (rx_frame)
    );

    assign irq = ctrl.ti | ctrl.ri;

endmodule

// File: tb/mp_uart_tb_top.sv
`timescale 1ns/1ps
module mp_uart_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_addr = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       txd;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] tdiv = 2'd0;
    logic [7:0] rbuf_m = 8'h00;
    logic       rx9_m = 1'b0;

    always #2.5 clk = ~clk;

    // baud tick: one cycle in four, 64 clocks per bit
    always @(negedge clk) begin
        tdiv      <= tdiv + 2'd1;
        baud_tick <= (tdiv == 2'd3);
    end

    mp_uart dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .baud_tick(baud_tick),
        .rxd(rxd), .txd(txd), .irq(irq)
    );

    function automatic logic [7:0] mk_ctrl(input int mode, input bit ri, input bit ti,
                                           input bit tx9, input bit mp, input bit rxen);
        return {2'(mode), ri, ti, 1'b0, tx9, mp, rxen};
    endfunction

    function automatic bit accept_fn(input bit mp, input bit ninth);
        return !mp || ninth;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send_frame(input logic [7:0] d, input bit nine, input bit b9, input bit stp);
        @(negedge clk);
        rxd = 1'b0;
        repeat (64) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (64) @(negedge clk);
        end
        if (nine) begin
            rxd = b9;
            repeat (64) @(negedge clk);
        end
        rxd = stp;
        repeat (64) @(negedge clk);
        rxd = 1'b1;
        repeat (64) @(negedge clk);
    endtask

    task automatic recv_tx(input bit nine, output logic [7:0] d, output logic b9,
                           output logic stp, output bit seen);
        int w;
        w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (txd && w < 2000);
        seen = !txd;
        repeat (32) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (64) @(negedge clk);
            d[i] = txd;
        end
        b9 = 1'b1;
        if (nine) begin
            repeat (64) @(negedge clk);
            b9 = txd;
        end
        repeat (64) @(negedge clk);
        stp = txd;
    endtask

    task automatic check_rx(input string tag, input bit exp_ri);
        logic [7:0] c;
        logic [7:0] d;
        rd_reg(1'b0, c);
        rd_reg(1'b1, d);
        chk({tag, " done flag"}, int'(c[5]), int'(exp_ri));
        chk({tag, " data"}, int'(d), int'(rbuf_m));
        chk({tag, " extra bit"}, int'(c[3]), int'(rx9_m));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] c, d, got;
        logic b9, stp;
        bit seen;
        int lows;
        void'($urandom(32'd7321));

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_reg(1'b0, c);
        chk("R1 ctrl", int'(c), 0);
        rd_reg(1'b1, d);
        chk("R1 data", int'(d), 0);
        chk("R1 txd", int'(txd), 1);
        chk("R1 irq", int'(irq), 0);

        // R2 layout, extra received bit read-only
        wr_reg(1'b0, 8'h4F);
        rd_reg(1'b0, c);
        chk("R2 readback", int'(c), 32'h47);

        // R3 / R4 / R11 directed 9-bit transmit
        wr_reg(1'b0, mk_ctrl(2, 0, 0, 1, 0, 0));
        fork
            wr_reg(1'b1, 8'hA5);
            recv_tx(1'b1, got, b9, stp, seen);
        join
        chk("R3 start seen", int'(seen), 1);
        chk("R3 data", int'(got), 32'hA5);
        chk("R3 extra", int'(b9), 1);
        chk("R3 stop", int'(stp), 1);
        repeat (64) @(negedge clk);
        rd_reg(1'b0, c);
        chk("R4 ti set", int'(c[4]), 1);
        chk("R11 irq on ti", int'(irq), 1);
        repeat (300) @(negedge clk);
        rd_reg(1'b0, c);
        chk("R4 ti held", int'(c[4]), 1);
        wr_reg(1'b0, mk_ctrl(2, 0, 0, 1, 0, 0));
        rd_reg(1'b0, c);
        chk("R4 ti cleared", int'(c[4]), 0);
        chk("R11 irq off", int'(irq), 0);

        // R3 write while busy ignored
        wr_reg(1'b0, mk_ctrl(1, 0, 0, 0, 0, 0));
        fork
            wr_reg(1'b1, 8'h3C);
            recv_tx(1'b0, got, b9, stp, seen);
            begin
                repeat (100) @(negedge clk);
                wr_reg(1'b1, 8'hC3);
            end
        join
        chk("R3 busy first frame", int'(got), 32'h3C);
        lows = 0;
        repeat (400) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        chk("R3 busy no second frame", lows, 0);

        // R3 random transmit across modes 01/10/11
        for (int it = 0; it < 4; it++) begin
            int m;
            bit t9;
            logic [7:0] v;
            m  = int'($urandom_range(1, 3));
            t9 = 1'($urandom);
            v  = 8'($urandom);
            wr_reg(1'b0, mk_ctrl(m, 0, 0, t9, 0, 0));
            fork
                wr_reg(1'b1, v);
                recv_tx(m >= 2, got, b9, stp, seen);
            join
            chk("R3 rand data", int'(got), int'(v));
            chk("R3 rand extra", int'(b9), (m >= 2) ? int'(t9) : 1);
            chk("R3 rand stop", int'(stp), 1);
            repeat (100) @(negedge clk);
        end

        // R6 mode 00: no transmit
        wr_reg(1'b0, mk_ctrl(0, 0, 0, 0, 0, 1));
        wr_reg(1'b1, 8'h00);
        lows = 0;
        repeat (800) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        chk("R6 mode00 txd idle", lows, 0);
        rd_reg(1'b0, c);
        chk("R6 mode00 ti", int'(c[4]), 0);

        // R6 no reception: mode 00, then receive disabled
        send_frame(8'h22, 0, 0, 1);
        check_rx("R6 mode00 rx", 0);
        wr_reg(1'b0, mk_ctrl(1, 0, 0, 0, 0, 0));
        send_frame(8'h11, 0, 0, 1);
        check_rx("R6 rx disabled", 0);

        // R5 short start pulse abandoned
        wr_reg(1'b0, mk_ctrl(1, 0, 0, 0, 0, 1));
        @(negedge clk);
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (1000) @(negedge clk);
        check_rx("R5 glitch", 0);

        // R5 / R7 valid frame, stop 1
        send_frame(8'h5A, 0, 0, 1);
        rbuf_m = 8'h5A; rx9_m = 1'b1;
        check_rx("R7 stop1", 1);
        chk("R11 irq on ri", int'(irq), 1);

        // R7 stop 0 still completes, extra bit 0
        wr_reg(1'b0, mk_ctrl(1, 0, 0, 0, 0, 1));
        send_frame(8'h3C, 0, 0, 0);
        rbuf_m = 8'h3C; rx9_m = 1'b0;
        check_rx("R7 stop0", 1);

        // R8 filter drops stop 0 in mode 01
        wr_reg(1'b0, mk_ctrl(1, 0, 0, 0, 1, 1));
        send_frame(8'h77, 0, 0, 0);
        check_rx("R8 drop", 0);

        // R10 9-bit filter
        wr_reg(1'b0, mk_ctrl(2, 0, 0, 0, 1, 1));
        send_frame(8'h99, 1, 0, 1);
        check_rx("R10 data frame dropped", 0);
        send_frame(8'h66, 1, 1, 1);
        rbuf_m = 8'h66; rx9_m = 1'b1;
        check_rx("R10 address frame", 1);

        // R9 mode 11 without filter
        wr_reg(1'b0, mk_ctrl(3, 0, 0, 0, 0, 1));
        send_frame(8'hE7, 1, 0, 1);
        rbuf_m = 8'hE7; rx9_m = 1'b0;
        check_rx("R9 ninth 0", 1);

        // R8 / R9 / R10 random reception
        for (int it = 0; it < 8; it++) begin
            int m;
            bit mp, n9, ninth, acc;
            logic [7:0] v;
            m  = int'($urandom_range(1, 3));
            mp = 1'($urandom);
            n9 = 1'($urandom);
            v  = 8'($urandom);
            wr_reg(1'b0, mk_ctrl(m, 0, 0, 0, mp, 1));
            send_frame(v, m >= 2, n9, 1);
            ninth = (m >= 2) ? n9 : 1'b1;
            acc   = accept_fn(mp, ninth);
            if (acc) begin
                rbuf_m = v;
                rx9_m  = ninth;
            end
            check_rx((m >= 2) ? "R10 rand" : "R8 rand", acc);
        end

        // R12 hardware set against a same-cycle clearing write
        begin
            bit last_wr, hit, coll;
            last_wr = 0; hit = 0; coll = 0;
            wr_reg(1'b0, mk_ctrl(1, 0, 0, 0, 0, 1));
            fork
                send_frame(8'h81, 0, 0, 1);
                begin
                    repeat (64 * 9) @(negedge clk);
                    for (int i = 0; i < 160; i++) begin
                        @(negedge clk);
                        if (irq && !hit) begin
                            hit = 1;
                            if (last_wr) coll = 1;
                        end
                        reg_addr  = 1'b0;
                        reg_wdata = mk_ctrl(1, 0, 0, 0, 0, 1);
                        reg_wr    = !irq && !hit;
                        last_wr   = reg_wr;
                    end
                    reg_wr = 1'b0;
                end
            join
            rbuf_m = 8'h81; rx9_m = 1'b1;
            chk("R12 write on set edge", int'(coll), 1);
            check_rx("R12 collision", 1);
            chk("R12 irq", int'(irq), 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule